// File: doc/BRIEF.md
# Asynchronous message list sequencer

This block controls the list pointer of a command/response bus controller. A normal message list is started by a CPU start command and moves forward one step for each completed message. The CPU can also ask the controller to leave that list and run a secondary, interrupt-style list that begins at a programmable address.

The request does not cut into the bus traffic. It is held until the message in progress finishes, or it is taken at once if the controller is idle. At the switch, the pointer where the normal list would have continued is saved in a one-entry return stack, together with a flag that records whether the controller was idle. The secondary list then runs until the fetch unit decodes a return opcode. The return restores the saved pointer and either resumes the normal list or goes back to idle.

While the secondary list runs, start commands and new secondary-list requests are refused. A refused request is dropped rather than queued, and a one-cycle flag reports that it was refused. Instruction fetch and message execution are outside this block and appear only as strobes.

Top module: `async_list_seq`

## Requirements
- R1: After reset, `list_ptr_o` is 0, `busy_o` and `in_async_o` are 0, `start_en_o` and `async_en_o` are 1, and `async_rej_o` is 0.
- R2: When idle, a `start_i` pulse with `start_en_o` high loads `start_ptr_i` into the pointer and sets `busy_o` on the next cycle. A start while already running has no effect.
- R3: When running, each `msg_done_i` pulse advances the pointer by STEP (default 1) on the next cycle. While idle, `msg_done_i` has no effect.
- R4: In the normal list, opcode 2 (halt) on `op_i` with `op_valid_i` returns the controller to idle and keeps the pointer.
- R5: An accepted request clears `async_en_o` on the next cycle. The switch happens one cycle after acceptance if the controller is idle. If the normal list is running, it happens at the first `msg_done_i` after the acceptance cycle.
- R6: At the switch, the pointer loads `async_ptr_i` and `in_async_o` rises. The saved pointer is the advanced pointer when leaving the normal list, and the unchanged pointer when leaving idle.
- R7: While the secondary list runs, `start_en_o` and `async_en_o` are 0 and `start_i` has no effect. A request is refused: it is not queued, and `async_rej_o` pulses on the next cycle.
- R8: Opcode 1 (return) in the secondary list restores the saved pointer. The controller then resumes the normal list (`busy_o`=1) or goes idle, according to where it came from, and both enables are 1 on the next cycle.
- R9: Opcode 1 outside the secondary list, and opcode 2 inside it, are ignored.
- R10: A request that arrives while an earlier request is still waiting for its switch is refused and flagged through `async_rej_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | CPU start command for the normal list |
| start_ptr_i | input | PTR_W | Normal list start address |
| async_req_i | input | 1 | CPU request for the secondary list |
| async_ptr_i | input | PTR_W | Secondary list start address |
| msg_done_i | input | 1 | Current message completed |
| op_valid_i | input | 1 | Decoded opcode valid |
| op_i | input | 2 | Decoded opcode: 1 return, 2 halt |
| list_ptr_o | output | PTR_W | Current list pointer |
| busy_o | output | 1 | Controller running a list |
| in_async_o | output | 1 | Secondary list active |
| start_en_o | output | 1 | Start command accepted |
| async_en_o | output | 1 | Secondary-list request accepted |
| async_rej_o | output | 1 | Previous-cycle request was refused |

## Verification
The hardest case to reach is a request that waits for a message boundary and then collides with other events. Examples are a second request or a halt arriving while the first request is pending, and a return that must send the controller back to idle rather than to the list. Directed sequences reach these cases: a request is made in the middle of a list, rejected requests and starts are driven during the secondary list, and a request is made from idle.

A long random phase follows with dense done, opcode and request pulses. In that phase, pending switches land on halts, and returns coincide with message completions. A behavioural model in the bench follows every cycle of both phases.

// File: rtl/alseq_pkg.sv
package alseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NORM  = 2'd1,
    ST_ASYNC = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RETAS = 2'd1,
    OP_HALT  = 2'd2,
    OP_RSVD  = 2'd3
  } seq_op_e;
endpackage

// File: rtl/alseq_req_gate.sv
module alseq_req_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic open_i,   // mode allows requests
  input  logic clr_i,    // switch taken
  output logic pend_o,
  output logic en_o,
  output logic rej_o
);
  logic pend_q, rej_q;

  assign en_o   = open_i & ~pend_q;
  assign pend_o = pend_q;
  assign rej_o  = rej_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      rej_q <= req_i & ~en_o;
      if (clr_i)             pend_q <= 1'b0;
      else if (req_i & en_o) pend_q <= 1'b1;
    end
  end

  assert_rej_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_q |-> $past(req_i));
  assert_pend_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/alseq_ret_stack.sv
module alseq_ret_stack #(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PTR_W-1:0] push_ptr_i,
  input  logic             push_idle_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] top_ptr_o,
  output logic             top_idle_o,
  output logic             full_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             idle_q, full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      idle_q <= 1'b0;
      full_q <= 1'b0;
    end else if (push_i) begin
      ptr_q  <= push_ptr_i;
      idle_q <= push_idle_i;
      full_q <= 1'b1;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end

  assign top_ptr_o  = ptr_q;
  assign top_idle_o = idle_q;
  assign full_o     = full_q;

  assert_no_push_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_q);
  assert_no_pop_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> full_q);
endmodule

// File: rtl/alseq_ptr_unit.sv
module alseq_ptr_unit #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_nxt_o   // pointer after one step
);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);
  logic [PTR_W-1:0] ptr_q;

  assign ptr_nxt_o = ptr_q + STEP_V;
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (ld_i)  ptr_q <= ld_val_i;
    else if (adv_i) ptr_q <= ptr_nxt_o;
  end
endmodule

// File: rtl/async_list_seq.sv
module async_list_seq
  import alseq_pkg::*;
#(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned STEP  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PTR_W-1:0] start_ptr_i,
  input  logic             async_req_i,
  input  logic [PTR_W-1:0] async_ptr_i,
  input  logic             msg_done_i,
  input  logic             op_valid_i,
  input  logic [1:0]       op_i,
  output logic [PTR_W-1:0] list_ptr_o,
  output logic             busy_o,
  output logic             in_async_o,
  output logic             start_en_o,
  output logic             async_en_o,
  output logic             async_rej_o
);
  seq_st_e          st_q, st_d;
  logic             pend, gate_en;
  logic             sw_go, ret_go, halt_go, start_go, adv;
  logic             ld;
  logic [PTR_W-1:0] ld_val, ptr, ptr_nxt, stk_ptr;
  logic             stk_idle, stk_full;

  // switch only at a message boundary, or immediately from idle
  assign sw_go    = pend & ((st_q == ST_IDLE) | ((st_q == ST_NORM) & msg_done_i));
  assign ret_go   = (st_q == ST_ASYNC) & op_valid_i & (op_i == OP_RETAS);
  assign halt_go  = (st_q == ST_NORM) & op_valid_i & (op_i == OP_HALT) & ~sw_go;
  assign start_go = (st_q == ST_IDLE) & start_i & ~sw_go;
  assign adv      = msg_done_i & (st_q != ST_IDLE) & ~ret_go;

  always_comb begin
    ld     = 1'b1;
    ld_val = ptr;
    if (sw_go)         ld_val = async_ptr_i;
    else if (ret_go)   ld_val = stk_ptr;
    else if (start_go) ld_val = start_ptr_i;
    else               ld = 1'b0;
  end

  always_comb begin
    st_d = st_q;
    if (sw_go)         st_d = ST_ASYNC;
    else if (ret_go)   st_d = stk_idle ? ST_IDLE : ST_NORM;
    else if (halt_go)  st_d = ST_IDLE;
    else if (start_go) st_d = ST_NORM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  alseq_req_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (async_req_i),
    .open_i (st_q != ST_ASYNC),
    .clr_i  (sw_go),
    .pend_o (pend),
    .en_o   (gate_en),
    .rej_o  (async_rej_o)
  );

  alseq_ret_stack #(.PTR_W(PTR_W)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (sw_go),
    .push_ptr_i  ((st_q == ST_IDLE) ? ptr : ptr_nxt),
    .push_idle_i (st_q == ST_IDLE),
    .pop_i       (ret_go),
    .top_ptr_o   (stk_ptr),
    .top_idle_o  (stk_idle),
    .full_o      (stk_full)
  );

  alseq_ptr_unit #(.PTR_W(PTR_W), .STEP(STEP)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld),
    .ld_val_i  (ld_val),
    .adv_i     (adv),
    .ptr_o     (ptr),
    .ptr_nxt_o (ptr_nxt)
  );

  assign list_ptr_o = ptr;
  assign busy_o     = st_q != ST_IDLE;
  assign in_async_o = st_q == ST_ASYNC;
  assign start_en_o = st_q != ST_ASYNC;
  assign async_en_o = gate_en;

  assert_switch_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_async_o) |-> $past(pend));
  assert_async_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_go |=> (list_ptr_o == $past(async_ptr_i)) && in_async_o);
  assert_async_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_async_o && !ret_go) |=> in_async_o);
  assert_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_go |=> (list_ptr_o == $past(stk_ptr)) && !in_async_o);
  assert_stack_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_async_o |-> stk_full);
endmodule

// File: tb/async_list_seq_tb.sv
`timescale 1ns/1ps
module async_list_seq_tb;
  localparam int W = 16;
  localparam int WD_NS = 2_000_000;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 0, req = 0, done = 0, opv = 0;
  logic [1:0]   op = 0;
  logic [W-1:0] sptr = 0, aptr = 0;
  logic [W-1:0] ptr_o;
  logic         busy_o, inas_o, sen_o, aen_o, rej_o;

  int total = 0, bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  async_list_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_ptr_i(sptr),
    .async_req_i(req), .async_ptr_i(aptr), .msg_done_i(done),
    .op_valid_i(opv), .op_i(op), .list_ptr_o(ptr_o), .busy_o(busy_o),
    .in_async_o(inas_o), .start_en_o(sen_o), .async_en_o(aen_o),
    .async_rej_o(rej_o)
  );

  // reference model: mode 0 idle, 1 list, 2 secondary
  int m_mode, m_ptr, m_sav_ptr;
  bit m_pend, m_sav_idle, m_rej;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ptr = 0; m_sav_ptr = 0; m_pend = 0; m_sav_idle = 0; m_rej = 0;
    end else begin
      bit open, sw, rt, hl, go, ad;
      int nmode, nptr;
      open = (m_mode != 2) && !m_pend;
      sw = m_pend && (m_mode == 0 || (m_mode == 1 && done));
      rt = (m_mode == 2) && opv && op == 2'd1;
      hl = (m_mode == 1) && opv && op == 2'd2 && !sw;
      go = (m_mode == 0) && start && !sw;
      ad = done && m_mode != 0 && !rt;
      nmode = m_mode; nptr = m_ptr;
      if (ad) nptr = (m_ptr + 1) % 65536;
      if (sw) begin
        m_sav_ptr = (m_mode == 0) ? m_ptr : (m_ptr + 1) % 65536;
        m_sav_idle = (m_mode == 0);
        nptr = aptr; nmode = 2;
      end else if (rt) begin
        nptr = m_sav_ptr; nmode = m_sav_idle ? 0 : 1;
      end else if (hl) nmode = 0;
      else if (go) begin nptr = sptr; nmode = 1; end
      m_rej = req && !open;
      if (sw) m_pend = 0; else if (req && open) m_pend = 1;
      m_mode = nmode; m_ptr = nptr;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk("R3 R6 R8 list_ptr", ptr_o, m_ptr);
    chk("R2 R4 busy", busy_o, m_mode != 0);
    chk("R6 R8 in_async", inas_o, m_mode == 2);
    chk("R7 start_en", sen_o, m_mode != 2);
    chk("R5 R10 async_en", aen_o, (m_mode != 2) && !m_pend);
    chk("R7 R10 async_rej", rej_o, m_rej);
  end

  task automatic tick();
    @(posedge clk); #2;
    start = 0; req = 0; done = 0; opv = 0; op = 0;
  endtask

  initial begin
    #WD_NS;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk("R1 ptr", ptr_o, 0); chk("R1 busy", busy_o, 0); chk("R1 inas", inas_o, 0);
    chk("R1 sen", sen_o, 1); chk("R1 aen", aen_o, 1); chk("R1 rej", rej_o, 0);
    done = 1; tick();
    chk("R3 idle done ignored", ptr_o, 0);
    sptr = 16'h0100; start = 1; tick();
    chk("R2 start load", ptr_o, 16'h0100); chk("R2 busy", busy_o, 1);
    sptr = 16'h0555; start = 1; tick();
    chk("R2 start while running", ptr_o, 16'h0100);
    repeat (3) begin done = 1; tick(); end
    chk("R3 advance", ptr_o, 16'h0103);
    aptr = 16'h0800; req = 1; tick();
    chk("R5 aen drops", aen_o, 0); chk("R5 no switch yet", inas_o, 0);
    req = 1; tick();
    chk("R10 pending reject", rej_o, 1);
    tick();
    chk("R5 waits for boundary", inas_o, 0);
    done = 1; tick();
    chk("R6 switch ptr", ptr_o, 16'h0800); chk("R6 in_async", inas_o, 1);
    chk("R7 sen low", sen_o, 0); chk("R7 aen low", aen_o, 0);
    sptr = 16'h0222; start = 1; tick();
    chk("R7 start ignored", ptr_o, 16'h0800);
    req = 1; tick();
    chk("R7 req rejected", rej_o, 1);
    opv = 1; op = 2'd2; tick();
    chk("R9 halt in async", inas_o, 1);
    done = 1; tick(); done = 1; tick();
    chk("R3 async advance", ptr_o, 16'h0802);
    opv = 1; op = 2'd1; tick();
    chk("R8 restore ptr", ptr_o, 16'h0104); chk("R8 resume busy", busy_o, 1);
    chk("R8 sen", sen_o, 1); chk("R8 aen", aen_o, 1);
    chk("R7 not queued", inas_o, 0);
    opv = 1; op = 2'd1; tick();
    chk("R9 return outside", ptr_o, 16'h0104);
    opv = 1; op = 2'd2; tick();
    chk("R4 halt idle", busy_o, 0); chk("R4 halt ptr", ptr_o, 16'h0104);
    aptr = 16'h0900; req = 1; tick();
    chk("R5 idle pend", inas_o, 0);
    tick();
    chk("R6 idle switch", ptr_o, 16'h0900); chk("R6 idle inas", inas_o, 1);
    done = 1; tick();
    opv = 1; op = 2'd1; tick();
    chk("R8 back to idle", busy_o, 0); chk("R8 idle ptr", ptr_o, 16'h0104);
    // random phase, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      done  = ($urandom_range(3) == 0);
      start = ($urandom_range(15) == 0);
      req   = ($urandom_range(11) == 0);
      opv   = ($urandom_range(5) == 0);
      op    = 2'($urandom_range(3));
      sptr  = 16'($urandom);
      aptr  = 16'($urandom);
      tick();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule